// File: doc/BRIEF.md
# Warp Branch Divergence and Reconvergence Controller

This block steers control flow for a single warp of 32 threads that share one program counter. Each cycle it presents the PC of the instruction to issue and the mask of threads that take part in it; threads whose mask bit is clear are held idle for that instruction. Upstream logic reports whether the instruction at the presented PC is a conditional branch. If it is, upstream also supplies a per-thread taken vector, the branch target, the fall-through address and the address where both sides of the branch join again.

If every participating thread goes the same way, the warp simply moves to that address and nothing is saved. If the threads split, the block first follows the taken side with only the taken threads enabled. Two entries go onto a hardware stack. One is the deferred fall-through side with its threads. The other is a merge entry that holds the join address and the full pre-branch mask. Each time the running PC equals the join address of the current context, the block spends one cycle popping the stack. The first pop switches to the deferred side. The second pop resumes at the join address with the original mask. Nesting repeats this per level, so the splits can go down to single threads when the stack is deep enough.

A stack-depth output and a same-cycle reconvergence indicator are provided for checking. A sticky error flag records any split that arrives when the stack lacks room for two more entries.

Top module: `warp_reconv_ctrl`

## Requirements
- R1: After reset the PC equals the RESET_PC parameter (0 by default), the mask is all ones (32'hFFFF_FFFF), the stack depth is 0, and both at_reconv and overflow_err are low.
- R2: With issue_en high and no branch, the PC advances by one and the mask is unchanged. With issue_en low, PC, mask and depth hold and any branch input is ignored.
- R3: A branch is uniform when (br_taken AND mask) is either all the active threads or none of them. A uniform branch moves the PC to br_target or br_fallthru respectively and leaves the mask and depth unchanged. Taken bits of inactive threads have no effect.
- R4: On a split branch, in the next cycle the PC is br_target, the mask is (br_taken AND mask), and the depth has grown by two.
- R5: at_reconv is high in a cycle exactly when issue_en is high, the depth is non-zero and the PC equals the join address of the running context. In the next cycle the depth is one lower and the PC and mask come from the popped entry: the fall-through address with the not-taken threads after the first pop of a split.
- R6: The second pop of a split resumes at the join address with the mask that was active when the branch was taken.
- R7: A split inside a deferred path nests: its two pops restore the inner pre-branch mask, and the outer join is taken later in the same way.
- R8: A branch presented in a cycle where at_reconv is high takes effect one cycle later, after the pop, and is evaluated against the popped mask.
- R9: A split seen when the depth plus two exceeds the DEPTH parameter pushes nothing and sets overflow_err, which then stays high until reset. The warp continues at br_target with the taken threads, and the depth stays unchanged and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_en | input | 1 | Instruction at cur_pc issues this cycle |
| br_valid | input | 1 | The issuing instruction is a conditional branch |
| br_taken | input | WARP_W (32) | Per-thread branch condition |
| br_target | input | PC_W (16) | Taken address |
| br_fallthru | input | PC_W (16) | Not-taken address |
| br_reconv | input | PC_W (16) | Join address of the branch |
| cur_pc | output | PC_W (16) | PC to issue |
| cur_mask | output | WARP_W (32) | Threads enabled for cur_pc |
| stack_depth | output | $clog2(DEPTH+1) | Entries held on the stack |
| at_reconv | output | 1 | This cycle is a reconvergence pop |
| overflow_err | output | 1 | Sticky stack-overflow flag |

## Verification
cur_pc, cur_mask, stack_depth and overflow_err are registered. The effect of inputs driven before a rising edge appears after that edge, so the bench drives on a falling edge and compares on the next falling edge. at_reconv is combinational from state and issue_en, so it is checked one time unit after the inputs are driven, still before the edge that performs the pop. A branch that collides with a pop takes two edges to show its effect, and the bench checks the state after each of the two edges.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  // Outcome of a branch against the current active mask.
  typedef enum logic [1:0] {
    BK_FALL  = 2'd0,
    BK_TAKEN = 2'd1,
    BK_SPLIT = 2'd2
  } br_kind_e;

  // A split consumes a merge entry and a deferred-path entry.
  localparam int unsigned SPLIT_ENTRIES = 2;

  function automatic logic room_for_split(input int unsigned used, input int unsigned cap);
    return (used + SPLIT_ENTRIES) <= cap;
  endfunction
endpackage

// File: rtl/wrs_branch_eval.sv
module wrs_branch_eval
  import wrs_pkg::*;
#(
  parameter int WARP_W = 32
) (
  input  logic [WARP_W-1:0] act_mask,
  input  logic [WARP_W-1:0] taken_raw,
  output br_kind_e          kind,
  output logic [WARP_W-1:0] taken_mask,
  output logic [WARP_W-1:0] fall_mask
);
  function automatic br_kind_e classify(input logic [WARP_W-1:0] t, input logic [WARP_W-1:0] f);
    if (t == '0)      return BK_FALL;
    else if (f == '0) return BK_TAKEN;
    else              return BK_SPLIT;
  endfunction

  always_comb begin
    taken_mask = act_mask & taken_raw;
    fall_mask  = act_mask & ~taken_raw;
    kind       = classify(taken_mask, fall_mask);
  end

  // The two sides always partition the active threads.
  always_comb begin
    assert_partition_R3: assert ((taken_mask & fall_mask) == '0 && (taken_mask | fall_mask) == act_mask);
  end
endmodule

// File: rtl/wrs_stack.sv
module wrs_stack #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 16,
  parameter int WARP_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push2,
  input  logic              pop,
  input  logic [PC_W-1:0]   lo_pc,
  input  logic [WARP_W-1:0] lo_mask,
  input  logic [PC_W-1:0]   lo_rpc,
  input  logic [PC_W-1:0]   hi_pc,
  input  logic [WARP_W-1:0] hi_mask,
  input  logic [PC_W-1:0]   hi_rpc,
  output logic [PC_W-1:0]   top_pc,
  output logic [WARP_W-1:0] top_mask,
  output logic [PC_W-1:0]   top_rpc,
  output logic [CNT_W-1:0]  count,
  output logic              room2
);
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [WARP_W-1:0] mask_q [DEPTH];
  logic [PC_W-1:0]   rpc_q  [DEPTH];

  always_comb begin
    room2    = wrs_pkg::room_for_split(int'(count), DEPTH);
    top_pc   = '0;
    top_mask = '0;
    top_rpc  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(count) == i + 1) begin
        top_pc   = pc_q[i];
        top_mask = mask_q[i];
        top_rpc  = rpc_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (pop) begin
      count <= count - 1'b1;
    end else if (push2) begin
      count <= count + CNT_W'(2);
    end
  end

  // Storage needs no reset: only entries below count are ever read.
  always_ff @(posedge clk) begin
    if (push2 && !pop) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (int'(count) == i) begin
          pc_q[i] <= lo_pc; mask_q[i] <= lo_mask; rpc_q[i] <= lo_rpc;
        end
        if (int'(count) + 1 == i) begin
          pc_q[i] <= hi_pc; mask_q[i] <= hi_mask; rpc_q[i] <= hi_rpc;
        end
      end
    end
  end

  assert_no_push_and_pop_R8: assert property (@(posedge clk) disable iff (!rst_n) !(push2 && pop));
  assert_no_pop_empty_R5:    assert property (@(posedge clk) disable iff (!rst_n) pop |-> count != '0);
  assert_depth_bound_R9:     assert property (@(posedge clk) disable iff (!rst_n) int'(count) <= DEPTH);
endmodule

// File: rtl/warp_reconv_ctrl.sv
module warp_reconv_ctrl
  import wrs_pkg::*;
#(
  parameter int              WARP_W   = 32,
  parameter int              PC_W     = 16,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int             CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  logic              br_valid,
  input  logic [WARP_W-1:0] br_taken,
  input  logic [PC_W-1:0]   br_target,
  input  logic [PC_W-1:0]   br_fallthru,
  input  logic [PC_W-1:0]   br_reconv,
  output logic [PC_W-1:0]   cur_pc,
  output logic [WARP_W-1:0] cur_mask,
  output logic [CNT_W-1:0]  stack_depth,
  output logic              at_reconv,
  output logic              overflow_err
);
  logic [PC_W-1:0]   cur_rpc;

  // Branch held over a pop cycle.
  logic              pend_v;
  logic [WARP_W-1:0] pend_taken;
  logic [PC_W-1:0]   pend_tgt, pend_ft, pend_rc;

  logic              eff_v;
  logic [WARP_W-1:0] eff_taken;
  logic [PC_W-1:0]   eff_tgt, eff_ft, eff_rc;

  br_kind_e          kind;
  logic [WARP_W-1:0] taken_mask, fall_mask;
  logic [PC_W-1:0]   top_pc, top_rpc;
  logic [WARP_W-1:0] top_mask;
  logic              room2;

  // Named events for the assertions.
  logic pop_now, exec_br, push_now, ovf_now;

  always_comb begin
    eff_v     = pend_v | br_valid;
    eff_taken = pend_v ? pend_taken : br_taken;
    eff_tgt   = pend_v ? pend_tgt   : br_target;
    eff_ft    = pend_v ? pend_ft    : br_fallthru;
    eff_rc    = pend_v ? pend_rc    : br_reconv;

    pop_now  = issue_en && (stack_depth != '0) && (cur_pc == cur_rpc);
    exec_br  = issue_en && !pop_now && eff_v;
    push_now = exec_br && (kind == BK_SPLIT) && room2;
    ovf_now  = exec_br && (kind == BK_SPLIT) && !room2;
  end

  assign at_reconv = pop_now;

  wrs_branch_eval #(.WARP_W(WARP_W)) u_eval (
    .act_mask   (cur_mask),
    .taken_raw  (eff_taken),
    .kind       (kind),
    .taken_mask (taken_mask),
    .fall_mask  (fall_mask)
  );

  // Lower entry: merge point with the pre-branch mask; upper: deferred path.
  wrs_stack #(.DEPTH(DEPTH), .PC_W(PC_W), .WARP_W(WARP_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push2    (push_now),
    .pop      (pop_now),
    .lo_pc    (eff_rc),
    .lo_mask  (cur_mask),
    .lo_rpc   (cur_rpc),
    .hi_pc    (eff_ft),
    .hi_mask  (fall_mask),
    .hi_rpc   (eff_rc),
    .top_pc   (top_pc),
    .top_mask (top_mask),
    .top_rpc  (top_rpc),
    .count    (stack_depth),
    .room2    (room2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pc       <= RESET_PC;
      cur_mask     <= '1;
      cur_rpc      <= '0;
      pend_v       <= 1'b0;
      pend_taken   <= '0;
      pend_tgt     <= '0;
      pend_ft      <= '0;
      pend_rc      <= '0;
      overflow_err <= 1'b0;
    end else if (issue_en) begin
      if (pop_now) begin
        cur_pc   <= top_pc;
        cur_mask <= top_mask;
        cur_rpc  <= top_rpc;
        if (br_valid && !pend_v) begin
          pend_v     <= 1'b1;
          pend_taken <= br_taken;
          pend_tgt   <= br_target;
          pend_ft    <= br_fallthru;
          pend_rc    <= br_reconv;
        end
      end else begin
        pend_v <= 1'b0;
        if (eff_v) begin
          unique case (kind)
            BK_FALL:  cur_pc <= eff_ft;
            BK_TAKEN: cur_pc <= eff_tgt;
            default: begin
              cur_pc   <= eff_tgt;
              cur_mask <= taken_mask;
              if (push_now) cur_rpc <= eff_rc;
              if (ovf_now)  overflow_err <= 1'b1;
            end
          endcase
        end else begin
          cur_pc <= cur_pc + 1'b1;
        end
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_en |=> $stable(cur_pc) && $stable(cur_mask) && $stable(stack_depth));
  assert_uniform_keeps_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_br && kind != BK_SPLIT) |=> $stable(cur_mask) && $stable(stack_depth));
  assert_split_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_now |=> int'(stack_depth) == int'($past(stack_depth)) + 2);
  assert_split_narrows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_now |=> (cur_mask & ~$past(cur_mask)) == '0 && cur_mask != $past(cur_mask));
  assert_pop_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    at_reconv |=> int'(stack_depth) == int'($past(stack_depth)) - 1);
  assert_mask_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mask != '0);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_now |=> overflow_err && $stable(stack_depth));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);
endmodule

// File: tb/warp_reconv_ctrl_bench.sv
`timescale 1ns/1ps
module warp_reconv_ctrl_bench;
  localparam int WARP_W = 32;
  localparam int PC_W   = 16;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              issue_en, br_valid;
  logic [WARP_W-1:0] br_taken;
  logic [PC_W-1:0]   br_target, br_fallthru, br_reconv;
  logic [PC_W-1:0]   cur_pc;
  logic [WARP_W-1:0] cur_mask;
  logic [CNT_W-1:0]  stack_depth;
  logic              at_reconv, overflow_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  warp_reconv_ctrl #(.WARP_W(WARP_W), .PC_W(PC_W), .DEPTH(DEPTH)) u_warp_reconv_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_en(issue_en), .br_valid(br_valid),
    .br_taken(br_taken), .br_target(br_target), .br_fallthru(br_fallthru),
    .br_reconv(br_reconv), .cur_pc(cur_pc), .cur_mask(cur_mask),
    .stack_depth(stack_depth), .at_reconv(at_reconv), .overflow_err(overflow_err)
  );

  typedef struct packed {
    logic        iss;
    logic        brv;
    logic [31:0] tk;
    logic [15:0] tgt;
    logic [15:0] ft;
    logic [15:0] rc;
    logic        pulse;
    logic [15:0] epc;
    logic [31:0] emask;
    logic [3:0]  edep;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b0, 16'h0001, 32'hFFFFFFFF, 4'd0},
    '{1'b1, 1'b1, 32'hFFFFFFFF,  16'h20, 16'h02, 16'h30, 1'b0, 16'h0020, 32'hFFFFFFFF, 4'd0},
    '{1'b1, 1'b1, 32'h00000000,  16'h40, 16'h21, 16'h50, 1'b0, 16'h0021, 32'hFFFFFFFF, 4'd0},
    '{1'b1, 1'b1, 32'h0000FFFF,  16'h30, 16'h22, 16'h40, 1'b0, 16'h0030, 32'h0000FFFF, 4'd2},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b0, 16'h0031, 32'h0000FFFF, 4'd2},
    '{1'b1, 1'b1, 32'hFFFF0000,  16'h3F, 16'h32, 16'h60, 1'b0, 16'h0032, 32'h0000FFFF, 4'd2},
    '{1'b1, 1'b1, 32'h0000FFFF,  16'h40, 16'h33, 16'h60, 1'b0, 16'h0040, 32'h0000FFFF, 4'd2},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b1, 16'h0022, 32'hFFFF0000, 4'd1},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b0, 16'h0023, 32'hFFFF0000, 4'd1},
    '{1'b1, 1'b1, 32'h00FF0000,  16'h50, 16'h51, 16'h52, 1'b0, 16'h0050, 32'h00FF0000, 4'd3},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b0, 16'h0051, 32'h00FF0000, 4'd3},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b0, 16'h0052, 32'h00FF0000, 4'd3},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b1, 16'h0051, 32'hFF000000, 4'd2},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b0, 16'h0052, 32'hFF000000, 4'd2},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b1, 16'h0052, 32'hFFFF0000, 4'd1},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b0, 16'h0053, 32'hFFFF0000, 4'd1},
    '{1'b0, 1'b1, 32'hFFFFFFFF,  16'h77, 16'h78, 16'h79, 1'b0, 16'h0053, 32'hFFFF0000, 4'd1},
    '{1'b1, 1'b1, 32'hFFFFFFFF,  16'h40, 16'h54, 16'h99, 1'b0, 16'h0040, 32'hFFFF0000, 4'd1},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b1, 16'h0040, 32'hFFFFFFFF, 4'd0},
    '{1'b1, 1'b0, 32'h0,         16'h0,  16'h0,  16'h0,  1'b0, 16'h0041, 32'hFFFFFFFF, 4'd0}
  };

  function automatic string req_of(input int i);
    case (i)
      0:           return "R2";
      1, 2, 5, 6:  return "R3";
      3, 4:        return "R4";
      7, 8:        return "R5";
      9, 10, 11:   return "R7";
      12, 13:      return "R7";
      14, 15:      return "R6";
      16:          return "R2";
      17:          return "R3";
      default:     return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic iss, input logic brv, input logic [31:0] tk,
                       input logic [15:0] tgt, input logic [15:0] ft, input logic [15:0] rc);
    issue_en = iss; br_valid = brv; br_taken = tk;
    br_target = tgt; br_fallthru = ft; br_reconv = rc;
  endtask

  task automatic check_state(input string req, input logic [15:0] pc, input logic [31:0] m, input int d);
    chk(req, "pc",    64'(cur_pc),      64'(pc));
    chk(req, "mask",  64'(cur_mask),    64'(m));
    chk(req, "depth", 64'(stack_depth), 64'(d));
  endtask

  task automatic do_reset();
    drive(1'b0, 1'b0, '0, '0, '0, '0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    check_state("R1", 16'h0000, 32'hFFFFFFFF, 0);
    chk("R1", "at_reconv",    64'(at_reconv),    64'd0);
    chk("R1", "overflow_err", 64'(overflow_err), 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].iss, VECS[i].brv, VECS[i].tk, VECS[i].tgt, VECS[i].ft, VECS[i].rc);
      #1;
      chk(VECS[i].pulse ? "R5" : req_of(i), "at_reconv", 64'(at_reconv), 64'(VECS[i].pulse));
      @(negedge clk);
      check_state(req_of(i), VECS[i].epc, VECS[i].emask, int'(VECS[i].edep));
    end
    chk("R9", "overflow_err clear", 64'(overflow_err), 64'd0);

    // R8: branch colliding with a pop
    do_reset();
    drive(1'b1, 1'b1, 32'h00000001, 16'h10, 16'h08, 16'h11);
    @(negedge clk);
    check_state("R4", 16'h0010, 32'h00000001, 2);
    drive(1'b1, 1'b0, '0, '0, '0, '0);
    @(negedge clk);
    drive(1'b1, 1'b1, 32'h0000000C, 16'h30, 16'h09, 16'h31);
    #1;
    chk("R8", "at_reconv", 64'(at_reconv), 64'd1);
    @(negedge clk);
    check_state("R8", 16'h0008, 32'hFFFFFFFE, 1);
    drive(1'b1, 1'b0, '0, '0, '0, '0);
    @(negedge clk);
    check_state("R8", 16'h0030, 32'h0000000C, 3);
    @(negedge clk);
    // R2: issue_en low blocks the pop at the join address
    drive(1'b0, 1'b0, '0, '0, '0, '0);
    #1;
    chk("R2", "at_reconv held", 64'(at_reconv), 64'd0);
    @(negedge clk);
    check_state("R2", 16'h0031, 32'h0000000C, 3);
    drive(1'b1, 1'b0, '0, '0, '0, '0);
    #1;
    chk("R5", "at_reconv", 64'(at_reconv), 64'd1);
    @(negedge clk);
    check_state("R5", 16'h0009, 32'hFFFFFFF2, 2);

    // R9: fill the stack, then overflow
    drive(1'b1, 1'b1, 32'h00000030, 16'h70, 16'h0A, 16'h0B);
    @(negedge clk);
    check_state("R4", 16'h0070, 32'h00000030, 4);
    chk("R9", "no error at full", 64'(overflow_err), 64'd0);
    drive(1'b1, 1'b1, 32'h00000010, 16'h80, 16'h71, 16'h72);
    @(negedge clk);
    check_state("R9", 16'h0080, 32'h00000010, 4);
    chk("R9", "overflow_err set", 64'(overflow_err), 64'd1);
    drive(1'b1, 1'b0, '0, '0, '0, '0);
    @(negedge clk);
    chk("R9", "overflow_err sticky", 64'(overflow_err), 64'd1);
    check_state("R9", 16'h0081, 32'h00000010, 4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule